// File: doc/BRIEF.md
# Partitionable Multiplier with Run-Time Signedness

This block multiplies two 72-bit operand buses. A two-bit mode input chooses how the buses are split into lanes. The lanes can be eight independent 9x9 products, four independent 18x18 products, or one 36x36 product. Two control inputs, one for each operand, choose at run time whether that operand is read as two's-complement or unsigned. The same choice applies to every lane at once.

The inputs are captured on one clock edge and the products are registered on the next. The block therefore has a fixed latency of two cycles. The mode and sign controls are captured together with their operands, so a new setting can be applied on every cycle without disturbing the products already in flight. All lane products are packed from bit 0 of a 144-bit result bus. A valid flag travels alongside them.

Top module: `lane_mult`

## Requirements
- R1: A rising clock edge with rst_n low clears the registers. From the next cycle, out_valid is 0 and result is all zero.
- R2: out_valid equals in_valid as it was sampled two rising edges earlier. The result computed from the operands sampled at that edge appears at the same time.
- R3: With mode 2'b00, lane i (i = 0..7) multiplies a[9i+8:9i] by b[9i+8:9i]. The 18-bit product is placed at result[18i+17:18i].
- R4: With mode 2'b01, lane i (i = 0..3) multiplies a[18i+17:18i] by b[18i+17:18i]. The 36-bit product is placed at result[36i+35:36i].
- R5: With mode 2'b10, the block multiplies a[35:0] by b[35:0] and places the 72-bit product at result[71:0]. result[143:72] is zero, and operand bits 71:36 have no effect.
- R6: sign_a = 1 makes every A lane a two's-complement value, and sign_a = 0 makes it unsigned. sign_b does the same for every B lane.
- R7: Each product keeps full precision, 2W bits for a W-bit lane. It is signed two's-complement when at least one operand is signed, and unsigned only when both operands are unsigned. This covers the most negative value, the all-ones pattern and zero.
- R8: The mode and sign settings are captured with the operands. Changing them on the next cycle does not alter a product that is already in flight.
- R9: mode 2'b11 is reserved and yields an all-zero result.
- R10: A zero A operand bus yields an all-zero result in every mode and sign setting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operands on a and b are valid this cycle |
| mode | input | 2 | Lane split: 00 = 8 x 9-bit, 01 = 4 x 18-bit, 10 = 1 x 36-bit, 11 = reserved |
| sign_a | input | 1 | 1 = A lanes are signed, 0 = unsigned |
| sign_b | input | 1 | 1 = B lanes are signed, 0 = unsigned |
| a | input | 72 | Operand A bus |
| b | input | 72 | Operand B bus |
| out_valid | output | 1 | Result bus holds a valid product set |
| result | output | 144 | Packed lane products |

## Verification
The hardest case to reach from the ports is a change of mode or sign while an earlier product is still inside the pipeline. Only there does a control that is not aligned with its operands give a visibly wrong answer. The bench issues back-to-back operations whose mode, sign settings and operands all change between consecutive cycles, and checks each result on its own cycle. It also walks every mode with all four sign pairs over operands built from the lane-wise most negative value, all ones and zero. Those operands expose the sign-extension corners that the inputs would otherwise seldom hit.

// File: rtl/lane_mult_pkg.sv
// Package: shared encodings for the partitionable multiplier.
// Assumes: mode is a two-bit field decoded only inside lane_mult.
package lane_mult_pkg;

    typedef enum logic [1:0] {
        MODE_NARROW = 2'd0,   // eight base-width lanes
        MODE_MID    = 2'd1,   // four double-width lanes
        MODE_WIDE   = 2'd2,   // one quad-width lane
        MODE_RSVD   = 2'd3    // reserved, result forced to zero
    } mode_e;

endpackage

// File: rtl/lane_mult_lane.sv
// Module: one full-precision multiplier lane of width W.
// Each operand is widened by one bit. The new top bit copies the operand's
// MSB when it is signed and is zero when it is unsigned. A signed multiply
// of the widened values then gives the exact product for every sign mix.
// Assumes: the product always fits in 2*W bits, which holds for all four
// sign combinations.
module lane_mult_lane #(
    parameter int W = 9
) (
    input  logic [W-1:0]   op_a,
    input  logic [W-1:0]   op_b,
    input  logic           sgn_a,
    input  logic           sgn_b,
    output logic [2*W-1:0] prod
);

    logic signed [W:0]     ext_a;
    logic signed [W:0]     ext_b;
    logic signed [2*W+1:0] full;

    // Widen the operands and form the exact signed product.
    always_comb begin
        ext_a = {sgn_a & op_a[W-1], op_a};
        ext_b = {sgn_b & op_b[W-1], op_b};
        full  = ext_a * ext_b;
        prod  = full[2*W-1:0];
    end

endmodule

// File: rtl/lane_mult_capture.sv
// Module: input capture stage.
// Registers the operands together with the mode, sign and valid controls,
// so that all of them enter the datapath on the same edge.
// Assumes: synchronous active-low reset.
module lane_mult_capture #(
    parameter int IN_W = 72
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    input  lane_mult_pkg::mode_e       mode_in,
    input  logic                       sign_a,
    input  logic                       sign_b,
    input  logic [IN_W-1:0]            a,
    input  logic [IN_W-1:0]            b,
    output logic                       q_valid,
    output lane_mult_pkg::mode_e       q_mode,
    output logic                       q_sign_a,
    output logic                       q_sign_b,
    output logic [IN_W-1:0]            q_a,
    output logic [IN_W-1:0]            q_b
);

    // Capture operands and controls in lock-step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_valid  <= 1'b0;
            q_mode   <= lane_mult_pkg::MODE_NARROW;
            q_sign_a <= 1'b0;
            q_sign_b <= 1'b0;
            q_a      <= '0;
            q_b      <= '0;
        end else begin
            q_valid  <= in_valid;
            q_mode   <= mode_in;
            q_sign_a <= sign_a;
            q_sign_b <= sign_b;
            q_a      <= a;
            q_b      <= b;
        end
    end

endmodule

// File: rtl/lane_mult.sv
// Module: partitionable multiplier, top level.
// Splits the operand buses into 8, 4 or 1 lanes according to mode and
// multiplies them with run-time signedness. The lane products are
// registered into a packed result bus. Latency is two cycles.
// Assumes: LANES is a multiple of 4, so that the mid and wide splits tile
// the bus exactly.
module lane_mult #(
    parameter int BASE_W = 9,
    parameter int LANES  = 8,
    localparam int IN_W  = BASE_W * LANES,
    localparam int RES_W = 2 * IN_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [1:0]       mode,
    input  logic             sign_a,
    input  logic             sign_b,
    input  logic [IN_W-1:0]  a,
    input  logic [IN_W-1:0]  b,
    output logic             out_valid,
    output logic [RES_W-1:0] result
);
    import lane_mult_pkg::*;

    localparam int MID_W  = 2 * BASE_W;
    localparam int MID_N  = LANES / 2;
    localparam int WIDE_W = 4 * BASE_W;

    logic             s1_valid;
    mode_e            s1_mode;
    logic             s1_sa;
    logic             s1_sb;
    logic [IN_W-1:0]  s1_a;
    logic [IN_W-1:0]  s1_b;

    logic [RES_W-1:0]    narrow_res;
    logic [RES_W-1:0]    mid_res;
    logic [2*WIDE_W-1:0] wide_prod;
    logic [RES_W-1:0]    sel_res;

    lane_mult_capture #(.IN_W(IN_W)) u_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .mode_in  (mode_e'(mode)),
        .sign_a   (sign_a),
        .sign_b   (sign_b),
        .a        (a),
        .b        (b),
        .q_valid  (s1_valid),
        .q_mode   (s1_mode),
        .q_sign_a (s1_sa),
        .q_sign_b (s1_sb),
        .q_a      (s1_a),
        .q_b      (s1_b)
    );

    // Base-width lanes.
    for (genvar i = 0; i < LANES; i++) begin : g_narrow
        lane_mult_lane #(.W(BASE_W)) u_lane (
            .op_a  (s1_a[i*BASE_W +: BASE_W]),
            .op_b  (s1_b[i*BASE_W +: BASE_W]),
            .sgn_a (s1_sa),
            .sgn_b (s1_sb),
            .prod  (narrow_res[i*2*BASE_W +: 2*BASE_W])
        );
    end

    // Double-width lanes.
    for (genvar i = 0; i < MID_N; i++) begin : g_mid
        lane_mult_lane #(.W(MID_W)) u_lane (
            .op_a  (s1_a[i*MID_W +: MID_W]),
            .op_b  (s1_b[i*MID_W +: MID_W]),
            .sgn_a (s1_sa),
            .sgn_b (s1_sb),
            .prod  (mid_res[i*2*MID_W +: 2*MID_W])
        );
    end

    // Single quad-width lane on the low bits of the buses.
    lane_mult_lane #(.W(WIDE_W)) u_wide (
        .op_a  (s1_a[WIDE_W-1:0]),
        .op_b  (s1_b[WIDE_W-1:0]),
        .sgn_a (s1_sa),
        .sgn_b (s1_sb),
        .prod  (wide_prod)
    );

    // Pick the product set that matches the captured mode.
    always_comb begin
        unique case (s1_mode)
            MODE_NARROW: sel_res = narrow_res;
            MODE_MID:    sel_res = mid_res;
            MODE_WIDE:   sel_res = {{(RES_W-2*WIDE_W){1'b0}}, wide_prod};
            default:     sel_res = '0;
        endcase
    end

    // Output register for the products and the valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
        end else begin
            out_valid <= s1_valid;
            result    <= sel_res;
        end
    end

endmodule

// File: rtl/lane_mult_chk.sv
// Module: assertion checker for lane_mult, attached by bind.
// It observes only the ports of the top module.
module lane_mult_chk #(
    parameter int IN_W  = 72,
    parameter int RES_W = 144
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [1:0]       mode,
    input logic [IN_W-1:0]  a,
    input logic             out_valid,
    input logic [RES_W-1:0] result
);

    // Reset clears the outputs (R1).
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && result == '0));

    // A valid input yields a valid output two cycles later (R2).
    p_valid_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##2 out_valid);

    // An idle input cycle yields an idle output cycle (R2).
    p_valid_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> ##2 !out_valid);

    // The wide mode leaves the upper half of the result at zero (R5).
    p_wide_upper_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b10) |-> ##2 (result[RES_W-1:RES_W/2] == '0));

    // The reserved mode yields zero (R9).
    p_rsvd_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b11) |-> ##2 (result == '0));

    // A zero A bus yields zero (R10).
    p_zero_operand_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (a == '0) |-> ##2 (result == '0));

endmodule

bind lane_mult lane_mult_chk #(.IN_W(IN_W), .RES_W(RES_W)) u_lane_mult_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .mode      (mode),
    .a         (a),
    .out_valid (out_valid),
    .result    (result)
);

// File: tb/lane_mult_bench.sv
// Bench for lane_mult. It walks a table of operand patterns over every mode
// and sign pair, then runs directed tests for reset, timing and corner cases.
module lane_mult_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NPAT = 4;
    localparam logic [71:0] PAT [0:NPAT-1] = '{
        72'hFF_FFFF_FFFF_FFFF_FFFF,
        72'h00_0000_0000_0000_0000,
        72'h5A_3CF0_0F12_34AB_CDEF,
        72'h81_7E02_FD04_FB08_F710
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [1:0]   mode = 2'b00;
    logic         sign_a = 1'b0;
    logic         sign_b = 1'b0;
    logic [71:0]  a = '0;
    logic [71:0]  b = '0;
    logic         out_valid;
    logic [143:0] result;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lane_mult u_lane_mult (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
        .sign_a(sign_a), .sign_b(sign_b), .a(a), .b(b),
        .out_valid(out_valid), .result(result)
    );

    // Reference model, written from the requirements.
    function automatic logic [143:0] model(input logic [1:0] m, input logic sa,
                                           input logic sb, input logic [71:0] x,
                                           input logic [71:0] y);
        logic [143:0] r;
        logic signed [145:0] xa, xb, pr;
        int w, n;
        r = '0;
        case (m)
            2'd0: begin w = 9;  n = 8; end
            2'd1: begin w = 18; n = 4; end
            2'd2: begin w = 36; n = 1; end
            default: begin w = 1; n = 0; end
        endcase
        for (int i = 0; i < n; i++) begin
            xa = '0;
            xb = '0;
            for (int k = 0; k < w; k++) begin
                xa[k] = x[i*w+k];
                xb[k] = y[i*w+k];
            end
            if (sa && xa[w-1]) xa = xa - (146'sd1 <<< w);
            if (sb && xb[w-1]) xb = xb - (146'sd1 <<< w);
            pr = xa * xb;
            for (int k = 0; k < 2*w; k++) r[i*2*w+k] = pr[k];
        end
        return r;
    endfunction

    // Lane-wise most negative pattern for a mode.
    function automatic logic [71:0] minneg(input logic [1:0] m);
        logic [71:0] p;
        int w;
        p = '0;
        w = (m == 2'd0) ? 9 : (m == 2'd1) ? 18 : 36;
        for (int i = 0; i < 72 / w; i++) p[i*w+w-1] = 1'b1;
        return p;
    endfunction

    task automatic check(input logic [143:0] act, input logic [143:0] exp,
                         input string tag);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic [1:0] m, input logic sa,
                         input logic sb, input logic [71:0] x, input logic [71:0] y);
        in_valid = v; mode = m; sign_a = sa; sign_b = sb; a = x; b = y;
    endtask

    // One isolated operation, sampled two edges after capture.
    task automatic run_one(input logic [1:0] m, input logic sa, input logic sb,
                           input logic [71:0] x, input logic [71:0] y,
                           input logic [143:0] exp, input string tag);
        @(negedge clk);
        drive(1'b1, m, sa, sb, x, y);
        @(negedge clk);
        drive(1'b0, 2'b00, 1'b0, 1'b0, '0, '0);
        @(negedge clk);
        check(result, exp, tag);
        check({143'd0, out_valid}, 144'd1, {tag, " valid"});
    endtask

    task automatic finish_run;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [71:0] pa, pb;
        repeat (3) @(negedge clk);
        // R1: state after reset
        check(result, '0, "R1 reset result");
        check({143'd0, out_valid}, '0, "R1 reset valid");
        rst_n = 1'b1;

        // R3 R4 R5 R6 R7: table walk over modes, sign pairs and patterns
        for (int m = 0; m < 3; m++) begin
            for (int s = 0; s < 4; s++) begin
                for (int p = 0; p <= NPAT; p++) begin
                    pa = (p == NPAT) ? minneg(2'(m)) : PAT[p];
                    pb = ((p + 2) % (NPAT + 1) == NPAT) ? minneg(2'(m)) : PAT[(p + 2) % (NPAT + 1)];
                    run_one(2'(m), s[1], s[0], pa, pb,
                            model(2'(m), s[1], s[0], pa, pb), "R3/R4/R5 R6 R7 table");
                end
            end
        end

        // R7: fixed corner values
        run_one(2'd0, 1'b0, 1'b0, {8{9'h1FF}}, {8{9'h1FF}}, {8{18'h3FC01}}, "R7 unsigned all-ones 9b");
        run_one(2'd0, 1'b1, 1'b1, {8{9'h100}}, {8{9'h100}}, {8{18'h10000}}, "R7 signed min*min 9b");
        run_one(2'd0, 1'b1, 1'b0, {8{9'h1FF}}, {8{9'h1FF}}, {8{18'h3FE01}}, "R6 mixed -1*511 9b");
        run_one(2'd2, 1'b1, 1'b1, 72'hFF_F_FFFF_FFFF, 72'hF_FFFF_FFFF, 144'd1, "R7 signed -1*-1 36b");
        // R5: upper operand bits ignored in wide mode
        run_one(2'd2, 1'b0, 1'b0, 72'hAB_C000_0000_03, 72'h12_3000_0000_05, 144'd15, "R5 upper bits ignored");
        // R9: reserved mode
        run_one(2'd3, 1'b1, 1'b1, PAT[0], PAT[2], '0, "R9 reserved");
        // R10: zero A bus
        run_one(2'd1, 1'b1, 1'b1, '0, PAT[3], '0, "R10 zero operand");

        // R2: valid timing edge by edge
        @(negedge clk);
        drive(1'b1, 2'd0, 1'b0, 1'b0, PAT[2], PAT[3]);
        @(negedge clk);
        drive(1'b0, 2'd0, 1'b0, 1'b0, '0, '0);
        check({143'd0, out_valid}, '0, "R2 not yet valid");
        @(negedge clk);
        check({143'd0, out_valid}, 144'd1, "R2 valid at two cycles");
        @(negedge clk);
        check({143'd0, out_valid}, '0, "R2 valid drops");

        // R8: back-to-back with changing mode and signs
        @(negedge clk);
        drive(1'b1, 2'd0, 1'b1, 1'b0, PAT[3], PAT[0]);
        @(negedge clk);
        drive(1'b1, 2'd2, 1'b0, 1'b1, PAT[2], minneg(2'd2));
        @(negedge clk);
        drive(1'b1, 2'd1, 1'b1, 1'b1, minneg(2'd1), PAT[0]);
        check(result, model(2'd0, 1'b1, 1'b0, PAT[3], PAT[0]), "R8 in-flight first");
        @(negedge clk);
        drive(1'b0, 2'd0, 1'b0, 1'b0, '0, '0);
        check(result, model(2'd2, 1'b0, 1'b1, PAT[2], minneg(2'd2)), "R8 in-flight second");
        @(negedge clk);
        check(result, model(2'd1, 1'b1, 1'b1, minneg(2'd1), PAT[0]), "R8 in-flight third");

        // R1: reset in the middle of traffic
        @(negedge clk);
        drive(1'b1, 2'd0, 1'b0, 1'b0, PAT[0], PAT[0]);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(result, '0, "R1 mid-run reset result");
        check({143'd0, out_valid}, '0, "R1 mid-run reset valid");
        rst_n = 1'b1;
        drive(1'b0, 2'd0, 1'b0, 1'b0, '0, '0);
        @(negedge clk);
        finish_run();
    end

endmodule